// File: doc/BRIEF.md
# Skip-Carry Grouped Adder

This block adds two N-bit words and a single carry input. The operand bits are split into groups of M adjacent bits. Inside each group the carry ripples from bit to bit. Beside each group sits a skip path. When every bit of the group propagates, meaning its two operand bits differ, the group's incoming carry goes straight to the group's outgoing carry through a 2:1 selector, and the internal ripple is not used. Each selector feeds the carry input of the group above it. The top group's outgoing carry becomes the adder's carry output.

All per-bit propagate and generate terms are formed in parallel before any carry is resolved. The sum and the carry output are captured in one output register that has a synchronous, active-high reset. A result therefore appears one clock after its operands. The default build is 16 bits in four groups of 4. Other widths are chosen by parameter, and the width must be a whole multiple of the group size.

Top module: `bypass_adder`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `sum_out` becomes all zeros and `c_out` becomes 0 after that edge, whatever the operand inputs are.
- R2: After a rising edge where `rst` is low, {`c_out`, `sum_out`} equals `a_in` + `b_in` + `c_in` as sampled at that edge. This is an unsigned (N+1)-bit result with one cycle of latency.
- R3: Each bit has propagate p = a xor b and generate g = a and b. Its sum bit is p xor the carry entering that bit, so equal operand bits produce a sum bit equal to the incoming carry.
- R4: In a group where at least one bit does not propagate, the group's carry-out is the carry rippled out of the group's top bit, with each bit's carry-out equal to g or (p and carry-in).
- R5: In a group whose propagate bits are all 1, the group's carry-out equals the group's carry-in.
- R6: Groups are chained from the least significant upward, each group's carry-out feeding the next group's carry-in. `c_out` is the carry-out of the most significant group.
- R7: N and M are parameters, and elaboration stops if N is not a multiple of M. A build of 12 bits in groups of 3 adds correctly.
- R8: With all-propagate operands (a xor b all ones), `sum_out` is all ones and `c_out` is 0 when `c_in` is 0, and `sum_out` is all zeros and `c_out` is 1 when `c_in` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output register loads on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_in | input | N | First operand |
| b_in | input | N | Second operand |
| c_in | input | 1 | Carry into the least significant bit |
| sum_out | output | N | Registered sum |
| c_out | output | 1 | Registered carry from the most significant group |

## Verification
All-propagate operands with the carry input set force every skip selector to pass its carry, so a wrong selector or a broken chain shows up at once. Patterns where a single group is all-propagate and its neighbours generate or kill separate the skip path of one group from the ripple paths of the others. Operands that are equal, all zeros or all ones exercise generate-only and kill-only columns. Seeded random operands cover the mixed cases. A second, narrower build confirms that the group structure follows its parameters.

// File: rtl/bypass_adder_pkg.sv
package bypass_adder_pkg;

    localparam int unsigned DEF_WIDTH = 16;
    localparam int unsigned DEF_GROUP = 4;

    // propagate / generate pair of one bit column
    typedef struct packed {
        logic prop;
        logic gen;
    } pg_bit_t;

    // carry status of one group
    typedef struct packed {
        logic skip;
        logic ripple;
        logic carry_out;
    } grp_stat_t;

    function automatic pg_bit_t make_pg(input logic x, input logic y);
        pg_bit_t r;
        r.prop = x ^ y;
        r.gen  = x & y;
        return r;
    endfunction

    function automatic logic carry_step(input pg_bit_t pg, input logic ci);
        return pg.gen | (pg.prop & ci);
    endfunction

endpackage

// File: rtl/bypass_pg_gen.sv
module bypass_pg_gen
    import bypass_adder_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output pg_bit_t          pg [WIDTH]
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_col
        assign pg[i] = make_pg(op_a[i], op_b[i]);
    end

endmodule

// File: rtl/bypass_group.sv
module bypass_group
    import bypass_adder_pkg::*;
#(
    parameter int unsigned GRP = DEF_GROUP
) (
    input  pg_bit_t        pg [GRP],
    input  logic           grp_cin,
    output logic [GRP-1:0] grp_sum,
    output grp_stat_t      stat
);

    logic [GRP-1:0] prop_vec;
    logic [GRP-1:0] sum_c;
    logic           rip_out;

    for (genvar i = 0; i < GRP; i++) begin : g_pv
        assign prop_vec[i] = pg[i].prop;
    end

    // ripple path inside the group
    always_comb begin
        logic c;
        c = grp_cin;
        for (int i = 0; i < GRP; i++) begin
            grp_sum[i] = pg[i].prop ^ c;
            sum_c[i]   = c;
            c          = carry_step(pg[i], c);
        end
        rip_out = c;
    end

    // skip selector
    always_comb begin
        stat.skip      = &prop_vec;
        stat.ripple    = rip_out;
        stat.carry_out = stat.skip ? grp_cin : rip_out;
    end

endmodule

// File: rtl/bypass_out_reg.sv
module bypass_out_reg #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] sum_d,
    input  logic             co_d,
    output logic [WIDTH-1:0] sum_q,
    output logic             co_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            co_q  <= 1'b0;
        end else begin
            sum_q <= sum_d;
            co_q  <= co_d;
        end
    end

endmodule

// File: rtl/bypass_adder.sv
module bypass_adder
    import bypass_adder_pkg::*;
#(
    parameter int unsigned N = DEF_WIDTH,
    parameter int unsigned M = DEF_GROUP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] b_in,
    input  logic         c_in,
    output logic [N-1:0] sum_out,
    output logic         c_out
);

    localparam int unsigned NG = N / M;

    // R7: width must split into whole groups
    if ((N % M) != 0 || M == 0) begin : g_bad_cfg
        $error("bypass_adder: N must be a multiple of M");
    end

    pg_bit_t   pg_all [N];
    logic [NG:0] chain;
    grp_stat_t st [NG];
    logic [N-1:0] sum_d;

    bypass_pg_gen #(.WIDTH(N)) u_pg (
        .op_a (a_in),
        .op_b (b_in),
        .pg   (pg_all)
    );

    assign chain[0] = c_in;

    for (genvar k = 0; k < NG; k++) begin : g_grp
        pg_bit_t pg_loc [M];
        for (genvar j = 0; j < M; j++) begin : g_sl
            assign pg_loc[j] = pg_all[k*M + j];
        end

        bypass_group #(.GRP(M)) u_grp (
            .pg      (pg_loc),
            .grp_cin (chain[k]),
            .grp_sum (sum_d[k*M +: M]),
            .stat    (st[k])
        );

        assign chain[k+1] = st[k].carry_out;

        // R5: a fully propagating group hands its carry-in straight on
        p_skip_pass_r5: assert property (@(posedge clk) disable iff (rst)
            st[k].skip |-> (chain[k+1] == chain[k]));

        // R4: otherwise the rippled carry from the top bit leaves the group
        p_ripple_out_r4: assert property (@(posedge clk) disable iff (rst)
            !st[k].skip |-> (chain[k+1] == st[k].ripple));
    end

    bypass_out_reg #(.WIDTH(N)) u_out (
        .clk   (clk),
        .rst   (rst),
        .sum_d (sum_d),
        .co_d  (chain[NG]),
        .sum_q (sum_out),
        .co_q  (c_out)
    );

    // R2: registered result equals the arithmetic sum of the previous inputs
    p_sum_match_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ({c_out, sum_out} ==
            ((N+1)'($past(a_in)) + (N+1)'($past(b_in)) + (N+1)'($past(c_in)))));

    // R6: carry output is the top group's carry from the previous cycle
    p_top_carry_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (c_out == $past(chain[NG])));

endmodule

// File: tb/bypass_adder_tb_top.sv
module bypass_adder_tb_top;

    localparam int unsigned N  = 16;
    localparam int unsigned M  = 4;
    localparam int unsigned NW = 12;
    localparam int unsigned MW = 3;
    localparam time CLK_P = 8ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] a = '0, b = '0;
    logic cin = 1'b0;
    logic [N-1:0] sum;
    logic co;
    logic [NW-1:0] aw = '0, bw = '0;
    logic cinw = 1'b0;
    logic [NW-1:0] sumw;
    logic cow;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    bypass_adder #(.N(N), .M(M)) dut_i (
        .clk(clk), .rst(rst), .a_in(a), .b_in(b), .c_in(cin),
        .sum_out(sum), .c_out(co)
    );

    bypass_adder #(.N(NW), .M(MW)) dut_w (
        .clk(clk), .rst(rst), .a_in(aw), .b_in(bw), .c_in(cinw),
        .sum_out(sumw), .c_out(cow)
    );

    function automatic logic [N:0] ref_add(input logic [N-1:0] x, input logic [N-1:0] y, input logic c);
        return (N+1)'(x) + (N+1)'(y) + (N+1)'(c);
    endfunction

    function automatic logic [NW:0] ref_add_w(input logic [NW-1:0] x, input logic [NW-1:0] y, input logic c);
        return (NW+1)'(x) + (NW+1)'(y) + (NW+1)'(c);
    endfunction

    task automatic check(input string req, input logic [N:0] got, input logic [N:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run(input logic [N-1:0] ta, input logic [N-1:0] tb, input logic tc, input string req);
        @(negedge clk);
        a = ta; b = tb; cin = tc;
        @(posedge clk);
        #1;
        check(req, {co, sum}, ref_add(ta, tb, tc));
    endtask

    task automatic run_w(input logic [NW-1:0] ta, input logic [NW-1:0] tb, input logic tc);
        @(negedge clk);
        aw = ta; bw = tb; cinw = tc;
        @(posedge clk);
        #1;
        check("R7", (N+1)'({cow, sumw}), (N+1)'(ref_add_w(ta, tb, tc)));
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] seed;
        seed = $urandom(32'd4711);
        a = 16'hBEEF; b = 16'h1234; cin = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset clears outputs despite nonzero inputs
        check("R1", {co, sum}, '0);
        @(negedge clk);
        rst = 1'b0;

        // R2, R3: zeros, generate-only and kill-only columns
        run(16'h0000, 16'h0000, 1'b0, "R2");
        run(16'h0000, 16'h0000, 1'b1, "R3");
        run(16'hFFFF, 16'hFFFF, 1'b0, "R3");
        run(16'hFFFF, 16'hFFFF, 1'b1, "R3");
        run(16'h5A5A, 16'h5A5A, 1'b1, "R3");
        // R8 / R5: every group skips
        run(16'hFFFF, 16'h0000, 1'b0, "R8");
        run(16'hFFFF, 16'h0000, 1'b1, "R8");
        run(16'hAAAA, 16'h5555, 1'b1, "R8");
        run(16'h0F0F, 16'hF0F0, 1'b1, "R5");
        // R4 / R5 / R6: one group propagates, others generate or kill
        for (int k = 0; k < N/M; k++) begin
            logic [N-1:0] ga, gb;
            ga = 16'hFFFF; gb = 16'hFFFF;
            ga[k*M +: M] = '1; gb[k*M +: M] = '0;
            run(ga, gb, 1'b0, "R5");
            ga = '0; gb = '0;
            ga[k*M +: M] = '1;
            run(ga, gb, 1'b1, "R6");
            ga = '0; gb = '0;
            ga[k*M] = 1'b1; gb[k*M] = 1'b1;
            run(ga, gb, 1'b0, "R4");
        end
        run(16'h8000, 16'h8000, 1'b0, "R6");
        run(16'h7FFF, 16'h0001, 1'b0, "R4");

        // R2: seeded random operands
        for (int i = 0; i < 2000; i++) begin
            run(N'($urandom), N'($urandom), 1'($urandom), "R2");
        end

        // R7: narrower build in groups of 3
        run_w(12'hFFF, 12'h000, 1'b1);
        run_w(12'hE38, 12'h1C7, 1'b0);
        run_w(12'hFFF, 12'hFFF, 1'b1);
        for (int i = 0; i < 300; i++) begin
            run_w(NW'($urandom), NW'($urandom), 1'($urandom));
        end

        // R1: reset in mid-run
        @(negedge clk);
        a = 16'hFFFF; b = 16'h0001; cin = 1'b1; rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1", {co, sum}, '0);
        @(negedge clk);
        rst = 1'b0;
        run(16'h1234, 16'h4321, 1'b0, "R2");

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule